// File: doc/BRIEF.md
# Double-Buffered Four-Channel DAC Register Interface

This block is the bus-slave side of a four-channel, 12-bit analog output stage. For every channel it keeps a shadow code register that the host writes and an active code register that drives the converter. The range setting (one bipolar bit and one gain bit per channel) is held the same way: a shadow word and an active copy. Reads on the bus do not return data. A read of a dedicated offset acts as a commit strobe. One such offset moves all four shadow codes into the active registers on the same clock edge. The other moves the shadow range word into the active range bits.

A mode word carries two bits. One enables the converters; while it is clear, every code output is forced to zero and the stored values are kept. The other selects buffered operation; with it clear, a data write goes straight to the active register of its channel. The range bits are packed so that channel `i` finds its bipolar bit at position 7−i and its gain bit at position 11−i. Shifting a channel-A mask right by the channel index therefore selects any channel. All registers clear on reset. The reset input is asynchronous and is released through a two-flop synchronizer.

Top module: `dac4_dbuf_regs`

## Requirements
- R1: On reset, all code outputs, bipolar bits and gain bits read zero, and both mode outputs are zero.
- R2: A write to offset 0x02 loads the mode word. Bit 1 is the converter enable (`dac_enable`) and bit 0 is buffered mode (`dac_buffered`). All other bits of that write are ignored.
- R3: A write to offset 0x14 + 2·i (i = 0..3, so A=0x14, B=0x16, C=0x18, D=0x1A) stores bits 11:0 of the write data in the shadow of channel i. Bits 15:12 are ignored.
- R4: In buffered mode a data write leaves the outputs unchanged. A read of offset 0x02 copies all four shadow codes to the active codes on one edge, visible the cycle after the read.
- R5: With buffered mode clear, a data write updates that channel's active code as well, visible the cycle after the write. If it coincides with a read of 0x02, the written value wins for that channel.
- R6: A write to offset 0x12 loads the shadow range word without changing the outputs. A read of 0x12 commits it: `out_bipolar[i]` takes bit 7−i and `out_gain[i]` takes bit 11−i.
- R7: While the enable bit is clear, all four code outputs read zero. Shadow and active registers keep their contents and reappear when the enable is set again.
- R8: In buffered mode, a read of 0x02 in the same cycle as a data write moves the old shadow value to the output. The new value lands in the shadow only.
- R9: A write to 0x12 in the same cycle as a read of 0x12 commits the old shadow range word. The new word stays in the shadow.
- R10: Writes and reads at any other offset, including odd offsets next to the used ones, change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe |
| bus_wr_addr | input | ADDR_W (8) | Write byte offset |
| bus_wr_data | input | BUS_W (16) | Write data |
| bus_rd_en | input | 1 | Read strobe, used as a commit trigger |
| bus_rd_addr | input | ADDR_W (8) | Read byte offset |
| out_code | output | NCH*CODE_W (48) | Active codes, channel i at bits i*12 +: 12 |
| out_bipolar | output | NCH (4) | Active bipolar bit per channel |
| out_gain | output | NCH (4) | Active gain bit per channel |
| dac_enable | output | 1 | Converter enable from the mode word |
| dac_buffered | output | 1 | Buffered-mode bit from the mode word |

## Verification
The bench sweeps every channel with edge codes and with data carrying junk in the upper bits. A decoder that kept bit 12 or more, or that aliased neighbouring offsets, would corrupt a different channel or a wrong bit. It drives a write and a commit read in the same cycle, for both codes and range words, to catch a design that forwards the new value instead of the old shadow. It toggles the enable around stored data to catch a design that clears registers instead of gating the outputs. It also switches between buffered and direct modes to catch a design that leaks shadow writes to the output early or needs a commit in direct mode.

// File: rtl/dac4_pkg.sv
package dac4_pkg;
  // Register offsets (byte addresses on the slave bus)
  localparam logic [15:0] OFS_MODE  = 16'h0002;
  localparam logic [15:0] OFS_RANGE = 16'h0012;
  localparam logic [15:0] OFS_DATA0 = 16'h0014;
  localparam int          OFS_STEP  = 2;

  // Bit positions inside the mode and range words
  localparam int ENA_BIT  = 1;
  localparam int BUFM_BIT = 0;
  localparam int BIP_MSB  = 7;
  localparam int GAIN_MSB = 11;

  typedef struct packed {
    logic enable;
    logic buffered;
  } dac_mode_t;
endpackage

// File: rtl/dac4_rst_sync.sv
module dac4_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/dac4_decode.sv
module dac4_decode
  import dac4_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 8
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [NCH-1:0]    wr_chan,
  output logic              wr_mode,
  output logic              wr_range,
  output logic              upd_code,
  output logic              upd_range
);
  for (genvar i = 0; i < NCH; i++) begin : g_chan_dec
    localparam int CH_OFS = int'(OFS_DATA0) + OFS_STEP * i;
    assign wr_chan[i] = wr_en && (wr_addr == ADDR_W'(CH_OFS));
  end

  assign wr_mode   = wr_en && (wr_addr == ADDR_W'(OFS_MODE));
  assign wr_range  = wr_en && (wr_addr == ADDR_W'(OFS_RANGE));
  assign upd_code  = rd_en && (rd_addr == ADDR_W'(OFS_MODE));
  assign upd_range = rd_en && (rd_addr == ADDR_W'(OFS_RANGE));
endmodule

// File: rtl/dac4_chan_buf.sv
module dac4_chan_buf #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              upd_stb,
  input  logic              direct,
  output logic [CODE_W-1:0] shadow_q,
  output logic [CODE_W-1:0] active_q
);
  logic              shadow_en;
  logic              active_en;
  logic [CODE_W-1:0] active_d;

  // Next state: a direct write beats the update; an update always
  // takes the shadow as it stood before this edge.
  always_comb begin
    shadow_en = wr_stb;
    active_en = upd_stb || (wr_stb && direct);
    if (wr_stb && direct) active_d = wr_code;
    else                  active_d = shadow_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (shadow_en) shadow_q <= wr_code;
      if (active_en) active_q <= active_d;
    end
  end
endmodule

// File: rtl/dac4_range_ctl.sv
module dac4_range_ctl #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_stb,
  input  logic [NCH-1:0] bip_in,
  input  logic [NCH-1:0] gain_in,
  input  logic           commit_stb,
  output logic [NCH-1:0] bip_sh_q,
  output logic [NCH-1:0] gain_sh_q,
  output logic [NCH-1:0] bip_act_q,
  output logic [NCH-1:0] gain_act_q
);
  logic [NCH-1:0] bip_sh_d, gain_sh_d, bip_act_d, gain_act_d;

  always_comb begin
    bip_sh_d   = bip_sh_q;
    gain_sh_d  = gain_sh_q;
    bip_act_d  = bip_act_q;
    gain_act_d = gain_act_q;
    if (wr_stb) begin
      bip_sh_d  = bip_in;
      gain_sh_d = gain_in;
    end
    if (commit_stb) begin
      bip_act_d  = bip_sh_q;
      gain_act_d = gain_sh_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bip_sh_q   <= '0;
      gain_sh_q  <= '0;
      bip_act_q  <= '0;
      gain_act_q <= '0;
    end else begin
      bip_sh_q   <= bip_sh_d;
      gain_sh_q  <= gain_sh_d;
      bip_act_q  <= bip_act_d;
      gain_act_q <= gain_act_d;
    end
  end
endmodule

// File: rtl/dac4_dbuf_regs.sv
module dac4_dbuf_regs
  import dac4_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CODE_W = 12,
  parameter int ADDR_W = 8,
  parameter int BUS_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr_en,
  input  logic [ADDR_W-1:0]     bus_wr_addr,
  input  logic [BUS_W-1:0]      bus_wr_data,
  input  logic                  bus_rd_en,
  input  logic [ADDR_W-1:0]     bus_rd_addr,
  output logic [NCH*CODE_W-1:0] out_code,
  output logic [NCH-1:0]        out_bipolar,
  output logic [NCH-1:0]        out_gain,
  output logic                  dac_enable,
  output logic                  dac_buffered
);
  localparam int CODES_W = NCH * CODE_W;

  logic                rst_sync_n;
  logic [NCH-1:0]      wr_chan;
  logic                wr_mode, wr_range, upd_code, upd_range;
  dac_mode_t           mode_q, mode_d;
  logic [CODES_W-1:0]  shadow_flat, active_flat;
  logic [NCH-1:0]      bip_in, gain_in, bip_sh, gain_sh;
  logic                unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wr_data[BUS_W-1:CODE_W];

  dac4_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  dac4_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
    .wr_en     (bus_wr_en),
    .wr_addr   (bus_wr_addr),
    .rd_en     (bus_rd_en),
    .rd_addr   (bus_rd_addr),
    .wr_chan   (wr_chan),
    .wr_mode   (wr_mode),
    .wr_range  (wr_range),
    .upd_code  (upd_code),
    .upd_range (upd_range)
  );

  // Mode word: next state then register
  always_comb begin
    mode_d = mode_q;
    if (wr_mode) begin
      mode_d.enable   = bus_wr_data[ENA_BIT];
      mode_d.buffered = bus_wr_data[BUFM_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) mode_q <= '0;
    else             mode_q <= mode_d;
  end

  // Per-channel code buffers
  for (genvar i = 0; i < NCH; i++) begin : g_chan
    dac4_chan_buf #(.CODE_W(CODE_W)) u_buf (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .wr_stb   (wr_chan[i]),
      .wr_code  (bus_wr_data[CODE_W-1:0]),
      .upd_stb  (upd_code),
      .direct   (!mode_q.buffered),
      .shadow_q (shadow_flat[i*CODE_W +: CODE_W]),
      .active_q (active_flat[i*CODE_W +: CODE_W])
    );

    // Channel-indexed bit extraction from the range word
    assign bip_in[i]  = bus_wr_data[BIP_MSB - i];
    assign gain_in[i] = bus_wr_data[GAIN_MSB - i];

    assign out_code[i*CODE_W +: CODE_W] =
      mode_q.enable ? active_flat[i*CODE_W +: CODE_W] : '0;
  end

  dac4_range_ctl #(.NCH(NCH)) u_rng (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_stb     (wr_range),
    .bip_in     (bip_in),
    .gain_in    (gain_in),
    .commit_stb (upd_range),
    .bip_sh_q   (bip_sh),
    .gain_sh_q  (gain_sh),
    .bip_act_q  (out_bipolar),
    .gain_act_q (out_gain)
  );

  assign dac_enable   = mode_q.enable;
  assign dac_buffered = mode_q.buffered;
endmodule

// File: rtl/dac4_dbuf_chk.sv
module dac4_dbuf_chk
  import dac4_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CODE_W = 12,
  parameter int ADDR_W = 8,
  parameter int BUS_W  = 16
) (
  input logic                  clk,
  input logic                  rst_sync_n,
  input logic                  bus_wr_en,
  input logic [ADDR_W-1:0]     bus_wr_addr,
  input logic [BUS_W-1:0]      bus_wr_data,
  input logic                  bus_rd_en,
  input logic [ADDR_W-1:0]     bus_rd_addr,
  input logic [NCH*CODE_W-1:0] out_code,
  input logic [NCH-1:0]        out_bipolar,
  input logic [NCH-1:0]        out_gain,
  input logic                  dac_buffered,
  input logic [NCH*CODE_W-1:0] shadow_flat,
  input logic [NCH*CODE_W-1:0] active_flat,
  input logic [NCH-1:0]        bip_sh,
  input logic [NCH-1:0]        gain_sh
);
  logic upd_c, upd_r, wr_a, wr_off;
  assign upd_c  = bus_rd_en && (bus_rd_addr == ADDR_W'(OFS_MODE));
  assign upd_r  = bus_rd_en && (bus_rd_addr == ADDR_W'(OFS_RANGE));
  assign wr_a   = bus_wr_en && (bus_wr_addr == ADDR_W'(OFS_DATA0));
  assign wr_off = bus_wr_en && (bus_wr_addr == ADDR_W'(OFS_MODE))
                  && !bus_wr_data[ENA_BIT];

  AST_DISABLE_ZEROES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_off |=> (out_code == '0));                                        // R7
  AST_UPDATE_COPIES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (upd_c && dac_buffered) |=> (active_flat == $past(shadow_flat)));    // R4
  AST_BUFFERED_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dac_buffered && !upd_c) |=> $stable(active_flat));                  // R4
  AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_a && !dac_buffered) |=> (active_flat[CODE_W-1:0] == $past(bus_wr_data[CODE_W-1:0]))); // R5
  AST_RANGE_COMMIT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    upd_r |=> (out_bipolar == $past(bip_sh) && out_gain == $past(gain_sh))); // R6
  AST_RANGE_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !upd_r |=> ($stable(out_bipolar) && $stable(out_gain)));             // R6
  AST_COLLIDE_OLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_a && upd_c && dac_buffered) |=>
      (active_flat[CODE_W-1:0] == $past(shadow_flat[CODE_W-1:0]) &&
       shadow_flat[CODE_W-1:0] == $past(bus_wr_data[CODE_W-1:0])));      // R8
endmodule

bind dac4_dbuf_regs dac4_dbuf_chk #(
  .NCH(NCH), .CODE_W(CODE_W), .ADDR_W(ADDR_W), .BUS_W(BUS_W)
) u_chk (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .bus_wr_en    (bus_wr_en),
  .bus_wr_addr  (bus_wr_addr),
  .bus_wr_data  (bus_wr_data),
  .bus_rd_en    (bus_rd_en),
  .bus_rd_addr  (bus_rd_addr),
  .out_code     (out_code),
  .out_bipolar  (out_bipolar),
  .out_gain     (out_gain),
  .dac_buffered (dac_buffered),
  .shadow_flat  (shadow_flat),
  .active_flat  (active_flat),
  .bip_sh       (bip_sh),
  .gain_sh      (gain_sh)
);

// File: tb/dac4_dbuf_regs_test.sv
module dac4_dbuf_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [47:0] out_code;
  logic [3:0]  out_bip, out_gain;
  logic        en_o, buf_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference model state
  logic [11:0] m_sh [4];
  logic [11:0] m_act[4];
  logic [3:0]  m_bsh, m_gsh, m_ba, m_ga;
  logic        m_en, m_buf;

  always #4 clk = ~clk;

  dac4_dbuf_regs uut (
    .clk(clk), .rst_n(rst_n),
    .bus_wr_en(wr_en), .bus_wr_addr(wr_addr), .bus_wr_data(wr_data),
    .bus_rd_en(rd_en), .bus_rd_addr(rd_addr),
    .out_code(out_code), .out_bipolar(out_bip), .out_gain(out_gain),
    .dac_enable(en_o), .dac_buffered(buf_o)
  );

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin m_sh[i] = '0; m_act[i] = '0; end
    m_bsh = '0; m_gsh = '0; m_ba = '0; m_ga = '0; m_en = 1'b0; m_buf = 1'b0;
  endtask

  // One bus cycle; called at a falling edge, returns at the next falling edge
  task automatic bus(input logic we, input logic [7:0] wa, input logic [15:0] wd,
                     input logic re, input logic [7:0] ra);
    logic [11:0] old_sh[4];
    logic [3:0]  ob, og;
    logic        obuf;
    wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
    @(posedge clk);
    for (int i = 0; i < 4; i++) old_sh[i] = m_sh[i];
    ob = m_bsh; og = m_gsh; obuf = m_buf;
    if (re && ra == 8'h02) for (int i = 0; i < 4; i++) m_act[i] = old_sh[i];
    if (re && ra == 8'h12) begin m_ba = ob; m_ga = og; end
    if (we) begin
      if (wa == 8'h02) begin m_en = wd[1]; m_buf = wd[0]; end
      if (wa == 8'h12) for (int i = 0; i < 4; i++) begin
        m_bsh[i] = wd[7-i]; m_gsh[i] = wd[11-i];
      end
      for (int i = 0; i < 4; i++) if (wa == 8'(8'h14 + 2*i)) begin
        m_sh[i] = wd[11:0];
        if (!obuf) m_act[i] = wd[11:0];
      end
    end
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic check_all(input string tag);
    logic [57:0] exp_v, act_v;
    logic [47:0] ec;
    for (int i = 0; i < 4; i++) ec[i*12 +: 12] = m_en ? m_act[i] : 12'h000;
    exp_v = {ec, m_ba, m_ga, m_en, m_buf};
    act_v = {out_code, out_bip, out_gain, en_o, buf_o};
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act_v, exp_v);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] vals[5];
    logic [7:0]  bad_w[7];
    logic [7:0]  bad_r[4];
    vals = '{12'h000, 12'hFFF, 12'h800, 12'h5A5, 12'h123};
    bad_w = '{8'h00, 8'h04, 8'h10, 8'h13, 8'h15, 8'h1C, 8'hFF};
    bad_r = '{8'h00, 8'h14, 8'h03, 8'h13};
    model_reset();
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1 reset state");

    // R2: mode word, other bits ignored
    bus(1, 8'h02, 16'hFFFC, 0, 8'h00); check_all("R2 mode bits clear");
    bus(1, 8'h02, 16'h0003, 0, 8'h00); check_all("R2 mode bits set");
    bus(1, 8'h02, 16'hF002, 0, 8'h00); check_all("R2 enable direct");

    // R3/R5: direct mode sweep, upper bits ignored
    for (int c = 0; c < 4; c++)
      for (int v = 0; v < 5; v++) begin
        bus(1, 8'(8'h14 + 2*c), {4'(v*3+c+1), vals[v] ^ 12'(c)}, 0, 8'h00);
        check_all("R5 R3 direct write");
      end

    // R4: buffered, writes held until update read
    bus(1, 8'h02, 16'h0003, 0, 8'h00);
    for (int p = 0; p < 3; p++) begin
      for (int c = 0; c < 4; c++) begin
        bus(1, 8'(8'h14 + 2*c), {4'hE, 12'(12'h3C1 * (p + 1) + c * 12'h111)}, 0, 8'h00);
        check_all("R4 buffered write held");
      end
      bus(0, 8'h00, 16'h0, 1, 8'h02); check_all("R4 update copies all");
    end

    // R6: range word sweep and commit
    for (int k = 0; k < 16; k++) begin
      bus(1, 8'h12, {4'hA, 4'(k), 4'(15-k), 4'h5}, 0, 8'h00);
      check_all("R6 range shadow only");
      bus(0, 8'h00, 16'h0, 1, 8'h12);
      check_all("R6 range commit");
    end

    // R7: disable gates codes, contents kept
    bus(1, 8'h02, 16'h0001, 0, 8'h00); check_all("R7 disabled zero");
    bus(1, 8'h16, 16'h0ABC, 0, 8'h00); check_all("R7 write while off");
    bus(0, 8'h00, 16'h0, 1, 8'h02);    check_all("R7 update while off");
    bus(1, 8'h02, 16'h0003, 0, 8'h00); check_all("R7 reenable shows values");

    // R8: collision of update and data write, buffered
    for (int c = 0; c < 4; c++) begin
      bus(1, 8'(8'h14 + 2*c), 16'(12'h700 + c), 0, 8'h00);
      bus(0, 8'h00, 16'h0, 1, 8'h02);
      bus(1, 8'(8'h14 + 2*c), 16'(12'h0F0 + c), 1, 8'h02);
      check_all("R8 collision keeps old");
      bus(0, 8'h00, 16'h0, 1, 8'h02);
      check_all("R8 next update new");
    end

    // R9: range collision
    bus(1, 8'h12, 16'h0F00, 0, 8'h00);
    bus(0, 8'h00, 16'h0, 1, 8'h12);    check_all("R9 first commit");
    bus(1, 8'h12, 16'h00F0, 1, 8'h12); check_all("R9 collision old word");
    bus(0, 8'h00, 16'h0, 1, 8'h12);    check_all("R9 later commit new");

    // R10: other offsets ignored
    for (int j = 0; j < 7; j++) begin
      bus(1, bad_w[j], 16'hFFFF, 0, 8'h00); check_all("R10 stray write");
    end
    for (int j = 0; j < 4; j++) begin
      bus(0, 8'h00, 16'h0, 1, bad_r[j]); check_all("R10 stray read");
    end

    // R5: direct write wins over coincident update
    bus(1, 8'h1A, 16'h0321, 0, 8'h00);
    bus(1, 8'h02, 16'h0002, 0, 8'h00);
    bus(1, 8'h18, 16'h0BEE, 1, 8'h02); check_all("R5 direct beats update");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule